// File: doc/BRIEF.md
# Hot-Plug Interrupt Locator Aggregator

This block condenses the pending-event state of a bank of hot-plug slots, plus a command-completion flag, into one 32-bit locator word that software reads to find which source wants attention. Each slot presents an event latch byte and a disable byte. A slot contributes its locator bit when any latched event is not masked by its disable byte. Bit 0 of the word belongs to command completion, and slot number `i`, counting from zero, owns bit `i+1`.

From the locator and a global interrupt-off bit the block derives one interrupt level. When the message mode strap is clear, that level drives a wire interrupt. When it is set, the wire stays low. In that case a one-clock request pulse is raised whenever the level differs from the level recorded on the previous clock. A resync input makes the block forget the recorded level, so a condition that is still pending is signalled again, for example after saved state has been restored. The latches and their clearing live in the register file that feeds this block.

Top module: `hpl_irq_locator`

## Requirements
- R1: For each slot `i` below NUM_SLOTS, locator bit `i+1` is 1 exactly when the bitwise AND of that slot's event byte with the inverse of its disable byte is nonzero.
- R2: Locator bit 0 is 1 exactly when the command-done input is 1 and the command-interrupt-off input is 0.
- R3: Locator bits above position NUM_SLOTS are always 0.
- R4: Locator, wire interrupt and message pulse are registered: each reflects the inputs sampled at the previous rising clock edge.
- R5: The interrupt level is 1 only when the global interrupt-off input is 0 and the locator is nonzero. The wire interrupt equals that level while message mode is 0, and is 0 while message mode is 1.
- R6: In message mode, the message pulse is high for one cycle when the new level differs from the level recorded on the prior cycle, in either direction. No pulse is raised when the level is unchanged, and none is raised while message mode is 0.
- R7: While resync is 1, the recorded level is treated as 0, so a pending level of 1 produces a pulse in message mode.
- R8: During reset, the locator, wire interrupt and message pulse are 0, and the recorded level is cleared. As a result, a level that is pending when reset ends is signalled by a pulse.
- R9: Event byte encoding: bit 0 presence change, bit 1 isolated power fault, bit 2 attention button, bit 3 retention latch change, bit 4 connected power fault. Each bit alone raises its slot's locator bit, and a disable byte with the same bit set masks it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slot_evt_i | input | NUM_SLOTS*EVT_W | Event latch bytes, slot 0 in the lowest byte |
| slot_dis_i | input | NUM_SLOTS*EVT_W | Per-slot disable bytes, same layout |
| cmd_done_i | input | 1 | Command completed flag |
| cmd_irq_off_i | input | 1 | Masks the command-completion source |
| irq_off_i | input | 1 | Global interrupt-off |
| msg_mode_i | input | 1 | Message-signalled mode strap |
| resync_i | input | 1 | Forget the recorded level |
| locator_o | output | 32 | Registered interrupt locator word |
| irq_o | output | 1 | Level wire interrupt |
| msg_pulse_o | output | 1 | One-cycle message request |

## Verification
The assertions take for granted that every input is stable around the rising edge and free of X once reset is released. They also assume that reset is held for at least one edge, because the past-value checks are only armed from the second clock after reset. The bench changes inputs only on the falling edge and releases reset on a falling edge. It holds resync for single cycles, so each sampled edge sees exactly one settled input set.

// File: rtl/hpl_pkg.sv
package hpl_pkg;
   localparam int LOC_W     = 32;
   localparam int MAX_SLOTS = LOC_W - 1;
   localparam int CMD_BIT   = 0;
   localparam int SLOT_BASE = 1;

   // event byte bit positions
   localparam int EV_PRESENT    = 0;
   localparam int EV_ISO_FAULT  = 1;
   localparam int EV_BUTTON     = 2;
   localparam int EV_LATCH      = 3;
   localparam int EV_CONN_FAULT = 4;

   typedef logic [LOC_W-1:0] loc_word_t;

   typedef struct packed {
      logic level;
      logic wire_irq;
      logic pulse;
   } notify_t;
endpackage

// File: rtl/hpl_slot_term.sv
module hpl_slot_term
   import hpl_pkg::*;
#(
   parameter int NUM_SLOTS = 31,
   parameter int EVT_W     = 8
) (
   input  logic [NUM_SLOTS*EVT_W-1:0] evt_i,
   input  logic [NUM_SLOTS*EVT_W-1:0] dis_i,
   output logic [NUM_SLOTS-1:0]       hit_o
);
   localparam int BUS_W = NUM_SLOTS * EVT_W;

   generate
      if (EVT_W < EV_CONN_FAULT + 1) begin : g_bad_width
         $error("hpl_slot_term: EVT_W too narrow for the event encoding");
      end
   endgenerate

   logic [BUS_W-1:0] live;
   assign live = evt_i & ~dis_i;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      assign hit_o[s] = |live[s*EVT_W +: EVT_W];
   end
endmodule

// File: rtl/hpl_loc_merge.sv
module hpl_loc_merge
   import hpl_pkg::*;
#(
   parameter int NUM_SLOTS = 31
) (
   input  logic [NUM_SLOTS-1:0] hit_i,
   input  logic                 cmd_done_i,
   input  logic                 cmd_irq_off_i,
   output loc_word_t            loc_o
);
   localparam int TOP_USED = SLOT_BASE + NUM_SLOTS;
   localparam int SPARE    = LOC_W - TOP_USED;

   assign loc_o[CMD_BIT] = cmd_done_i & ~cmd_irq_off_i;
   assign loc_o[TOP_USED-1:SLOT_BASE] = hit_i;

   generate
      if (SPARE > 0) begin : g_fill
         assign loc_o[LOC_W-1:TOP_USED] = '0;
      end
   endgenerate
endmodule

// File: rtl/hpl_notify.sv
module hpl_notify
   import hpl_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_ni,
   input  loc_word_t loc_i,
   input  logic      irq_off_i,
   input  logic      msg_mode_i,
   input  logic      resync_i,
   output loc_word_t loc_o,
   output logic      irq_o,
   output logic      pulse_o
);
   notify_t   nxt;
   loc_word_t loc_q;
   logic      irq_q, pulse_q, last_q;
   logic      prev;

   always_comb begin
      prev         = resync_i ? 1'b0 : last_q;
      nxt.level    = ~irq_off_i & (|loc_i);
      nxt.wire_irq = nxt.level & ~msg_mode_i;
      nxt.pulse    = msg_mode_i & (nxt.level ^ prev);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         loc_q   <= '0;
         irq_q   <= 1'b0;
         pulse_q <= 1'b0;
         last_q  <= 1'b0;
      end else begin
         loc_q   <= loc_i;
         irq_q   <= nxt.wire_irq;
         pulse_q <= nxt.pulse;
         last_q  <= nxt.level;
      end
   end

   assign loc_o   = loc_q;
   assign irq_o   = irq_q;
   assign pulse_o = pulse_q;
endmodule

// File: rtl/hpl_irq_locator.sv
module hpl_irq_locator
   import hpl_pkg::*;
#(
   parameter int NUM_SLOTS = 31,
   parameter int EVT_W     = 8
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic [NUM_SLOTS*EVT_W-1:0] slot_evt_i,
   input  logic [NUM_SLOTS*EVT_W-1:0] slot_dis_i,
   input  logic                       cmd_done_i,
   input  logic                       cmd_irq_off_i,
   input  logic                       irq_off_i,
   input  logic                       msg_mode_i,
   input  logic                       resync_i,
   output logic [31:0]                locator_o,
   output logic                       irq_o,
   output logic                       msg_pulse_o
);
   generate
      if (NUM_SLOTS < 1 || NUM_SLOTS > MAX_SLOTS) begin : g_bad_slots
         $error("hpl_irq_locator: NUM_SLOTS must be 1..31");
      end
   endgenerate

   logic [NUM_SLOTS-1:0] hit;
   loc_word_t            loc_comb;
   loc_word_t            loc_reg;

   hpl_slot_term #(.NUM_SLOTS(NUM_SLOTS), .EVT_W(EVT_W)) u_term (
      .evt_i (slot_evt_i),
      .dis_i (slot_dis_i),
      .hit_o (hit)
   );

   hpl_loc_merge #(.NUM_SLOTS(NUM_SLOTS)) u_merge (
      .hit_i         (hit),
      .cmd_done_i    (cmd_done_i),
      .cmd_irq_off_i (cmd_irq_off_i),
      .loc_o         (loc_comb)
   );

   hpl_notify u_notify (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .loc_i      (loc_comb),
      .irq_off_i  (irq_off_i),
      .msg_mode_i (msg_mode_i),
      .resync_i   (resync_i),
      .loc_o      (loc_reg),
      .irq_o      (irq_o),
      .pulse_o    (msg_pulse_o)
   );

   assign locator_o = loc_reg;
endmodule

// File: rtl/hpl_irq_locator_chk.sv
module hpl_irq_locator_chk #(
   parameter int NUM_SLOTS = 31,
   parameter int EVT_W     = 8
) (
   input logic                       clk_i,
   input logic                       rst_ni,
   input logic [NUM_SLOTS*EVT_W-1:0] slot_evt_i,
   input logic [NUM_SLOTS*EVT_W-1:0] slot_dis_i,
   input logic                       cmd_done_i,
   input logic                       cmd_irq_off_i,
   input logic                       irq_off_i,
   input logic                       msg_mode_i,
   input logic                       resync_i,
   input logic [31:0]                locator_o,
   input logic                       irq_o,
   input logic                       msg_pulse_o
);
   logic armed_q, off_q;
   logic lvl_seen;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         armed_q <= 1'b0;
         off_q   <= 1'b1;
      end else begin
         armed_q <= 1'b1;
         off_q   <= irq_off_i;
      end
   end

   assign lvl_seen = ~off_q & (locator_o != 32'd0);

   always @(posedge clk_i) begin
      if (!rst_ni) begin
         AST_RESET_QUIET: assert (locator_o == 32'd0 && !irq_o && !msg_pulse_o); // R8
      end
   end

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot_chk
      AST_SLOT_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
         armed_q |-> (locator_o[g+1] ==
            $past(|(slot_evt_i[g*EVT_W +: EVT_W] & ~slot_dis_i[g*EVT_W +: EVT_W])))); // R1
   end

   AST_CMD_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed_q |-> (locator_o[0] == $past(cmd_done_i && !cmd_irq_off_i))); // R2

   AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (locator_o >> (NUM_SLOTS + 1)) == 32'd0); // R3

   AST_WIRE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed_q && $past(msg_mode_i) |-> !irq_o); // R5

   AST_WIRE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed_q && !$past(msg_mode_i) |-> (irq_o == lvl_seen)); // R5

   AST_PULSE_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      msg_pulse_o |-> armed_q && $past(msg_mode_i)); // R6

   AST_PULSE_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed_q && $past(msg_mode_i) && !$past(resync_i)
         |-> (msg_pulse_o == (lvl_seen != $past(lvl_seen)))); // R6

   AST_RESYNC_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed_q && $past(msg_mode_i) && $past(resync_i) |-> (msg_pulse_o == lvl_seen)); // R7
endmodule

bind hpl_irq_locator hpl_irq_locator_chk #(.NUM_SLOTS(NUM_SLOTS), .EVT_W(EVT_W)) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .slot_evt_i    (slot_evt_i),
   .slot_dis_i    (slot_dis_i),
   .cmd_done_i    (cmd_done_i),
   .cmd_irq_off_i (cmd_irq_off_i),
   .irq_off_i     (irq_off_i),
   .msg_mode_i    (msg_mode_i),
   .resync_i      (resync_i),
   .locator_o     (locator_o),
   .irq_o         (irq_o),
   .msg_pulse_o   (msg_pulse_o)
);

// File: tb/test_hpl_irq_locator.sv
`timescale 1ns/1ps
module test_hpl_irq_locator;
   localparam int NS = 4;
   localparam int EW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NS*EW-1:0] evt = '0, dis = '0;
   logic cmd = 0, cmd_off = 0, off = 0, msg = 0, rsy = 0;
   logic [31:0] loc;
   logic irq, pulse;

   int total = 0, bad = 0;
   logic last_m = 1'b0;

   always #4 clk = ~clk;

   hpl_irq_locator #(.NUM_SLOTS(NS), .EVT_W(EW)) i_hpl_irq_locator (
      .clk_i(clk), .rst_ni(rst_n), .slot_evt_i(evt), .slot_dis_i(dis),
      .cmd_done_i(cmd), .cmd_irq_off_i(cmd_off), .irq_off_i(off),
      .msg_mode_i(msg), .resync_i(rsy), .locator_o(loc), .irq_o(irq),
      .msg_pulse_o(pulse));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // expected values from the requirements, then wait one edge and compare
   task automatic step(input string req);
      logic [31:0] e_loc;
      logic e_lvl, e_irq, e_pul, prev;
      e_loc = '0;
      for (int s = 0; s < NS; s++)
         e_loc[s+1] = |(evt[s*EW +: EW] & ~dis[s*EW +: EW]);   // R1
      e_loc[0] = cmd & ~cmd_off;                              // R2
      e_lvl = ~off & (e_loc != 0);
      e_irq = e_lvl & ~msg;
      prev  = rsy ? 1'b0 : last_m;
      e_pul = msg & (e_lvl != prev);
      last_m = e_lvl;
      @(negedge clk);
      chk({req, " locator"}, loc, e_loc);
      chk("R3 upper zero", loc >> (NS + 1), 32'd0);
      chk({req, " wire"}, {31'd0, irq}, {31'd0, e_irq});
      chk({req, " pulse"}, {31'd0, pulse}, {31'd0, e_pul});
   endtask

   initial begin
      #1_000_000;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R8 reset locator", loc, 32'd0);
      chk("R8 reset wire", {31'd0, irq}, 32'd0);
      chk("R8 reset pulse", {31'd0, pulse}, 32'd0);
      rst_n = 1'b1;
      step("R4 idle");

      // R9 / R1: every event bit of every slot, with masking variants
      for (int s = 0; s < NS; s++) begin
         for (int b = 0; b < EW; b++) begin
            evt = '0; dis = '0;
            evt[s*EW + b] = 1'b1;
            step("R9 single event");
            dis[s*EW +: EW] = 8'(1 << b);
            step("R9 same bit masked");
            dis[s*EW +: EW] = ~8'(1 << b);
            step("R1 other bits masked");
         end
      end
      // R1: all slots, mixed masks
      evt = {NS{8'h1f}}; dis = '0;
      step("R1 all slots");
      dis = {8'h00, 8'hff, 8'h10, 8'hef};
      step("R1 mixed masks");
      evt = '0; dis = '0;

      // R2: command source combinations
      for (int c = 0; c < 4; c++) begin
         cmd = c[0]; cmd_off = c[1];
         step("R2 command source");
      end
      cmd = 0; cmd_off = 0;

      // R5: wire level under global off
      evt[EW*2 + 2] = 1'b1;
      step("R5 wire high");
      off = 1;
      step("R5 global off");
      off = 0;
      step("R5 wire back");
      msg = 1;
      step("R6 enter message mode with level");
      step("R6 unchanged level");
      step("R6 unchanged level again");
      evt = '0;
      step("R6 level falls");
      step("R6 idle");
      cmd = 1;
      step("R6 level rises via command");
      off = 1;
      step("R6 global off drops level");
      off = 0;
      step("R6 level returns");

      // R7: resync with pending and without pending level
      rsy = 1;
      step("R7 resync pending");
      rsy = 0;
      step("R7 after resync");
      cmd = 0;
      step("R7 level falls");
      rsy = 1;
      step("R7 resync idle");
      rsy = 0;

      // R8: reset in flight with level pending, then pulse after release
      evt[0] = 1'b1;
      step("R6 set pending");
      rst_n = 0;
      #1;
      chk("R8 async reset locator", loc, 32'd0);
      chk("R8 async reset pulse", {31'd0, pulse}, 32'd0);
      last_m = 1'b0;
      @(negedge clk);
      rst_n = 1;
      step("R8 re-signal after reset");
      msg = 0;
      step("R5 wire mode again");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule